// File: doc/BRIEF.md
# Address Breakpoint Flag Unit

The unit keeps one breakpoint flag for every address of two separate 12-bit address spaces. One space covers program memory and the other covers external data memory. It watches the target processor's fetch addresses and its external data addresses, each qualified by its own address-valid strobe. When a strobed address has its flag set, the unit sends a one-cycle trigger pulse to a scope or logic analyser. If breaking is enabled, it also raises a halt request. A separate controller decides what to do with that request. The unit never stops the processor itself.

A host port sets, clears, reads and fills flags while the target is halted. Any combination of flags may be set. On reset, and on a fill command, a sweep counter writes one word of flags per clock. While the sweep runs, `busy_o` is high, host commands are dropped and strobes cannot hit.

Top module: `bkpt_flag_unit`

## Requirements
- R1: After reset is released, `busy_o` is high for 256 clocks while every flag in both spaces is cleared. Once it falls, every read returns 0. `trig_o`, `halt_req_o` and `host_rvalid_o` are 0 during reset.
- R2: The host op codes are 00 = read, 01 = set, 10 = clear and 11 = fill. Space 0 is program and space 1 is data. A set writes 1 to the flag at `host_addr_i` in the selected space. A read is answered on the following clock, with `host_rvalid_o` high and the flag on `host_rdata_o`. `host_rvalid_o` is low at all other times.
- R3: A clear writes 0 to the flag at `host_addr_i` in the selected space.
- R4: The two spaces are independent. A flag in one space never produces a hit for an access to the same address in the other space, and a write or fill to one space leaves the other space unchanged.
- R5: Any set of addresses can be flagged at once, including both ends 000h and FFFh. Every flagged address hits.
- R6: A strobe on a flagged address drives `trig_o` high on the next clock, for exactly one clock per strobed cycle. A program hit and a data hit in the same cycle give one pulse.
- R7: While `brk_en_i` is low, hits still pulse `trig_o`. `halt_req_o` is 0 on the clock after any cycle with `brk_en_i` low.
- R8: While `brk_en_i` is high, a hit sets `halt_req_o` on the next clock. It then stays high for as long as `brk_en_i` stays high.
- R9: A fill writes `host_fill_val_i` into every flag of the selected space. `busy_o` goes high on the clock after the request and stays high for 256 clocks. Host requests made while busy are ignored.
- R10: Strobes made while `busy_o` is high produce no hit.
- R11: A strobed address whose flag is 0 produces no pulse. A flagged address presented without its strobe produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_addr_i | input | 12 | Program fetch address |
| prog_vld_i | input | 1 | Program address valid strobe |
| data_addr_i | input | 12 | External data address |
| data_vld_i | input | 1 | Data address valid strobe |
| brk_en_i | input | 1 | Breaking enabled |
| host_req_i | input | 1 | Host command request |
| host_op_i | input | 2 | Host op: 00 read, 01 set, 10 clear, 11 fill |
| host_space_i | input | 1 | 0 program space, 1 data space |
| host_addr_i | input | 12 | Host flag address |
| host_fill_val_i | input | 1 | Value written by fill |
| host_rdata_o | output | 1 | Flag returned by a read |
| host_rvalid_o | output | 1 | Read data valid |
| busy_o | output | 1 | Clearing or fill sweep in progress |
| trig_o | output | 1 | One-cycle trigger pulse per hit cycle |
| halt_req_o | output | 1 | Halt request to the controller |

## Verification
The bench strobes flagged and unflagged addresses, and also a flagged address with its strobe low, so that a hit can be told apart from mere address equality. It presents the same address in both spaces to confirm that the flag stores are separate. It uses the ends 000h and FFFh and a full-space fill to show that any combination of flags works. Strobes are repeated with breaking disabled and then enabled, which separates the trigger pulse from the sticky halt request. Host commands and strobes issued during a sweep show that both are locked out while busy.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int NUM_SPACES = 2;
  localparam int SPACE_PROG = 0;
  localparam int SPACE_DATA = 1;

  typedef enum logic [1:0] {
    OP_READ = 2'b00,
    OP_SET  = 2'b01,
    OP_CLR  = 2'b10,
    OP_FILL = 2'b11
  } host_op_e;
endpackage

// File: rtl/bkpt_flag_store.sv
module bkpt_flag_store #(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 16,
  localparam int BIT_W = $clog2(WORD_W),
  localparam int WORDS = (1 << ADDR_W) / WORD_W,
  localparam int WIDX_W = ADDR_W - BIT_W
) (
  input  logic              clk_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              lk_flag_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_flag_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              wr_val_i,
  input  logic              sw_en_i,
  input  logic [WIDX_W-1:0] sw_word_i,
  input  logic              sw_val_i
);
  logic [WORD_W-1:0] mem_q [WORDS];

  // sweep wins; host writes are blocked by busy upstream anyway
  always_ff @(posedge clk_i) begin
    if (sw_en_i) begin
      mem_q[sw_word_i] <= {WORD_W{sw_val_i}};
    end else if (wr_en_i) begin
      mem_q[wr_addr_i[ADDR_W-1:BIT_W]][wr_addr_i[BIT_W-1:0]] <= wr_val_i;
    end
  end

  assign lk_flag_o = mem_q[lk_addr_i[ADDR_W-1:BIT_W]][lk_addr_i[BIT_W-1:0]];
  assign rd_flag_o = mem_q[rd_addr_i[ADDR_W-1:BIT_W]][rd_addr_i[BIT_W-1:0]];
endmodule

// File: rtl/bkpt_sweep.sv
module bkpt_sweep #(
  parameter int WORDS = 256,
  parameter int SPACES = 2,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              start_val_i,
  input  logic [SPACES-1:0] start_mask_i,
  output logic              busy_o,
  output logic [IDX_W-1:0]  word_o,
  output logic              val_o,
  output logic [SPACES-1:0] mask_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

  logic             busy_q, val_q;
  logic [IDX_W-1:0] cnt_q;
  logic [SPACES-1:0] mask_q;

  // reset starts a clearing sweep of every space
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      val_q  <= 1'b0;
      mask_q <= '1;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      val_q  <= start_val_i;
      mask_q <= start_mask_i;
    end
  end

  assign busy_o = busy_q;
  assign word_o = cnt_q;
  assign val_o  = val_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/bkpt_hit_logic.sv
module bkpt_hit_logic #(
  parameter int SPACES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SPACES-1:0] hit_i,
  input  logic              brk_en_i,
  output logic              trig_o,
  output logic              halt_o
);
  logic any_hit;
  logic trig_q, halt_q;

  assign any_hit = |hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      trig_q <= any_hit;
      if (!brk_en_i)    halt_q <= 1'b0;
      else if (any_hit) halt_q <= 1'b1;
    end
  end

  assign trig_o = trig_q;
  assign halt_o = halt_q;
endmodule

// File: rtl/bkpt_flag_unit.sv
module bkpt_flag_unit
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] prog_addr_i,
  input  logic              prog_vld_i,
  input  logic [ADDR_W-1:0] data_addr_i,
  input  logic              data_vld_i,
  input  logic              brk_en_i,
  input  logic              host_req_i,
  input  logic [1:0]        host_op_i,
  input  logic              host_space_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              host_fill_val_i,
  output logic              host_rdata_o,
  output logic              host_rvalid_o,
  output logic              busy_o,
  output logic              trig_o,
  output logic              halt_req_o
);
  localparam int BIT_W  = $clog2(WORD_W);
  localparam int WORDS  = (1 << ADDR_W) / WORD_W;
  localparam int WIDX_W = ADDR_W - BIT_W;

  host_op_e              op;
  logic                  busy, host_acc, sw_val;
  logic [WIDX_W-1:0]     sw_word;
  logic [NUM_SPACES-1:0] sw_mask, sel, lk_flag, rd_flag, vld, hit;
  logic [ADDR_W-1:0]     lk_addr [NUM_SPACES];
  logic                  rvalid_q, rdata_q;

  assign op       = host_op_e'(host_op_i);
  assign host_acc = host_req_i && !busy;
  assign sel      = host_space_i ? NUM_SPACES'(1 << SPACE_DATA) : NUM_SPACES'(1 << SPACE_PROG);

  assign lk_addr[SPACE_PROG] = prog_addr_i;
  assign lk_addr[SPACE_DATA] = data_addr_i;
  assign vld[SPACE_PROG]     = prog_vld_i;
  assign vld[SPACE_DATA]     = data_vld_i;

  for (genvar g = 0; g < NUM_SPACES; g++) begin : g_space
    bkpt_flag_store #(
      .ADDR_W(ADDR_W),
      .WORD_W(WORD_W)
    ) u_store (
      .clk_i     (clk_i),
      .lk_addr_i (lk_addr[g]),
      .lk_flag_o (lk_flag[g]),
      .rd_addr_i (host_addr_i),
      .rd_flag_o (rd_flag[g]),
      .wr_en_i   (host_acc && sel[g] && (op == OP_SET || op == OP_CLR)),
      .wr_addr_i (host_addr_i),
      .wr_val_i  (op == OP_SET),
      .sw_en_i   (busy && sw_mask[g]),
      .sw_word_i (sw_word),
      .sw_val_i  (sw_val)
    );
    assign hit[g] = vld[g] && lk_flag[g] && !busy;
  end

  bkpt_sweep #(
    .WORDS (WORDS),
    .SPACES(NUM_SPACES)
  ) u_sweep (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (host_acc && op == OP_FILL),
    .start_val_i  (host_fill_val_i),
    .start_mask_i (sel),
    .busy_o       (busy),
    .word_o       (sw_word),
    .val_o        (sw_val),
    .mask_o       (sw_mask)
  );

  bkpt_hit_logic #(
    .SPACES(NUM_SPACES)
  ) u_hit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (hit),
    .brk_en_i (brk_en_i),
    .trig_o   (trig_o),
    .halt_o   (halt_req_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= 1'b0;
    end else begin
      rvalid_q <= host_acc && op == OP_READ;
      if (host_acc && op == OP_READ) rdata_q <= rd_flag[host_space_i];
    end
  end

  assign host_rdata_o  = rdata_q;
  assign host_rvalid_o = rvalid_q;
  assign busy_o        = busy;
endmodule

// File: rtl/bkpt_flag_unit_chk.sv
module bkpt_flag_unit_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] prog_addr_i,
  input logic              prog_vld_i,
  input logic [ADDR_W-1:0] data_addr_i,
  input logic              data_vld_i,
  input logic              brk_en_i,
  input logic              host_req_i,
  input logic [1:0]        host_op_i,
  input logic              host_space_i,
  input logic [ADDR_W-1:0] host_addr_i,
  input logic              host_fill_val_i,
  input logic              host_rdata_o,
  input logic              host_rvalid_o,
  input logic              busy_o,
  input logic              trig_o,
  input logic              halt_req_o
);
  AST_RVALID_ONLY_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_req_i && host_op_i == 2'b00 && !busy_o) |=> !host_rvalid_o); // R2

  AST_READ_ANSWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_req_i && host_op_i == 2'b00 && !busy_o) |=> host_rvalid_o); // R2

  AST_NO_TRIG_WITHOUT_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prog_vld_i || data_vld_i) |=> !trig_o); // R11

  AST_NO_HALT_WHEN_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !brk_en_i |=> !halt_req_o); // R7

  AST_HALT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_req_o && brk_en_i) |=> halt_req_o); // R8

  AST_NO_HIT_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !trig_o); // R10

  AST_FILL_STARTS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_req_i && host_op_i == 2'b11 && !busy_o) |=> busy_o); // R9
endmodule

bind bkpt_flag_unit bkpt_flag_unit_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/bkpt_flag_unit_tb.sv
`timescale 1ns/1ps
module bkpt_flag_unit_tb;
  localparam int AW = 12;
  localparam int N = 1 << AW;
  localparam int SWEEP = N / 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] prog_addr = '0, data_addr = '0, host_addr = '0;
  logic prog_vld = 0, data_vld = 0, brk_en = 0, host_req = 0, host_space = 0, fill_val = 0;
  logic [1:0] host_op = 2'b00;
  logic rdata, rvalid, busy, trig, halt;

  int checks = 0, fails = 0;
  bit done = 0, cmp_on = 0;

  bit m_flags [2][N];
  int m_rem;
  bit m_trig, m_halt, m_rvalid, m_rdata;

  always #4 clk = ~clk;

  bkpt_flag_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .prog_addr_i(prog_addr), .prog_vld_i(prog_vld),
    .data_addr_i(data_addr), .data_vld_i(data_vld),
    .brk_en_i(brk_en), .host_req_i(host_req), .host_op_i(host_op),
    .host_space_i(host_space), .host_addr_i(host_addr), .host_fill_val_i(fill_val),
    .host_rdata_o(rdata), .host_rvalid_o(rvalid), .busy_o(busy),
    .trig_o(trig), .halt_req_o(halt)
  );

  // behavioural reference, stepped on every edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rem = SWEEP; m_trig = 0; m_halt = 0; m_rvalid = 0; m_rdata = 0;
      for (int s = 0; s < 2; s++) for (int a = 0; a < N; a++) m_flags[s][a] = 0;
    end else begin
      bit bz, ph, dh;
      bz = (m_rem > 0);
      ph = prog_vld && !bz && m_flags[0][prog_addr];
      dh = data_vld && !bz && m_flags[1][data_addr];
      m_trig = ph | dh;
      if (!brk_en) m_halt = 0; else if (ph | dh) m_halt = 1;
      if (bz) m_rem--;
      m_rvalid = 0;
      if (host_req && !bz) begin
        case (host_op)
          2'b00: begin m_rvalid = 1; m_rdata = m_flags[host_space][host_addr]; end
          2'b01: m_flags[host_space][host_addr] = 1;
          2'b10: m_flags[host_space][host_addr] = 0;
          default: begin
            for (int a = 0; a < N; a++) m_flags[host_space][a] = fill_val;
            m_rem = SWEEP;
          end
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_on && !done) begin
      chk(trig === m_trig, "R6 trig_o vs model", trig, m_trig);
      chk(halt === m_halt, "R8 halt_req_o vs model", halt, m_halt);
      chk(busy === (m_rem > 0), "R9 busy_o vs model", busy, m_rem > 0);
      chk(rvalid === m_rvalid, "R2 host_rvalid_o vs model", rvalid, m_rvalid);
      if (m_rvalid) chk(rdata === m_rdata, "R2 host_rdata_o vs model", rdata, m_rdata);
    end
  end

  task automatic host(input logic [1:0] op, input bit sp, input int a, input bit v);
    @(negedge clk);
    host_req = 1; host_op = op; host_space = sp; host_addr = AW'(a); fill_val = v;
    @(negedge clk);
    host_req = 0;
  endtask

  task automatic read_chk(input bit sp, input int a, input bit exp, input string tag);
    host(2'b00, sp, a, 0);
    chk(rvalid === 1'b1, {tag, " read valid"}, rvalid, 1);
    chk(rdata === exp, {tag, " read data"}, rdata, exp);
  endtask

  task automatic strobe(input bit pv, input int pa, input bit dv, input int da,
                        input bit exp, input string tag);
    @(negedge clk);
    prog_vld = pv; prog_addr = AW'(pa); data_vld = dv; data_addr = AW'(da);
    @(negedge clk);
    prog_vld = 0; data_vld = 0;
    chk(trig === exp, tag, trig, exp);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(trig === 0 && halt === 0 && rvalid === 0, "R1 outputs low in reset", trig, 0);
    rst_n = 1; cmp_on = 1;
    @(negedge clk);
    chk(busy === 1'b1, "R1 busy after reset", busy, 1);
    wait_idle();
    chk(busy === 1'b0, "R1 sweep finishes", busy, 0);
    read_chk(0, 'h123, 0, "R1 prog cleared");
    read_chk(1, 'hFFF, 0, "R1 data cleared");

    host(2'b01, 0, 'h123, 0);
    read_chk(0, 'h123, 1, "R2 set prog");
    read_chk(1, 'h123, 0, "R4 data space untouched");

    brk_en = 0;
    strobe(1, 'h123, 0, 0, 1, "R6 prog hit pulses");
    @(negedge clk);
    chk(trig === 0, "R6 pulse one clock wide", trig, 0);
    chk(halt === 0, "R7 no halt when disabled", halt, 0);
    strobe(0, 0, 1, 'h123, 0, "R4 data access at prog flag address");
    strobe(1, 'h124, 0, 0, 0, "R11 unflagged address");
    strobe(0, 'h123, 0, 0, 0, "R11 flagged address without strobe");

    host(2'b01, 1, 'h000, 0);
    host(2'b01, 1, 'hFFF, 0);
    strobe(0, 0, 1, 'hFFF, 1, "R5 top address hits");
    strobe(0, 0, 1, 'h000, 1, "R5 bottom address hits");
    strobe(1, 'h123, 1, 'h000, 1, "R6 simultaneous hits");
    @(negedge clk);
    chk(trig === 0, "R6 simultaneous hits give one pulse", trig, 0);

    @(negedge clk); brk_en = 1;
    strobe(1, 'h124, 0, 0, 0, "R8 miss does not halt");
    chk(halt === 0, "R8 halt low after miss", halt, 0);
    strobe(1, 'h123, 0, 0, 1, "R8 hit with breaking on");
    chk(halt === 1, "R8 halt raised", halt, 1);
    repeat (5) @(negedge clk);
    chk(halt === 1, "R8 halt held", halt, 1);
    brk_en = 0;
    @(negedge clk);
    chk(halt === 0, "R7 halt drops when disabled", halt, 0);

    host(2'b10, 0, 'h123, 0);
    read_chk(0, 'h123, 0, "R3 clear prog");
    strobe(1, 'h123, 0, 0, 0, "R3 cleared flag no hit");

    host(2'b01, 0, 'hABC, 0);
    host(2'b11, 1, 0, 1);
    chk(busy === 1, "R9 fill busy", busy, 1);
    host(2'b01, 0, 'h777, 0);
    strobe(0, 0, 1, 'h555, 0, "R10 no hit while busy");
    wait_idle();
    read_chk(0, 'h777, 0, "R9 request while busy ignored");
    read_chk(1, 'h321, 1, "R9 fill wrote ones");
    read_chk(0, 'hABC, 1, "R4 fill left prog space");
    strobe(0, 0, 1, 'h5A5, 1, "R5 every filled address hits");
    @(negedge clk);
    data_vld = 1; data_addr = 'h010;
    @(negedge clk); data_addr = 'h011;
    @(negedge clk); data_vld = 0;
    chk(trig === 1, "R6 back to back hits", trig, 1);
    @(negedge clk);
    chk(trig === 0, "R6 pulses end", trig, 0);

    host(2'b11, 1, 0, 0);
    wait_idle();
    read_chk(1, 'hFFF, 0, "R9 fill wrote zeros");
    read_chk(0, 'hABC, 1, "R4 prog kept after data fill");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule